// File: doc/BRIEF.md
# Ethernet receive frame queue

This block buffers received Ethernet frames for a processor. Frames enter as a byte stream with start, valid and end markers. Each accepted frame goes into one slot of a circular queue of `SLOTS` slots of `SLOT_BYTES` bytes each. The block stores every frame as a record with three parts: a 16-bit length prefix, the payload, and a CRC-32 trailer that the block computes.

Software reads a record as a sequence of 32-bit words from one data register. When the last word of a frame has been read, the queue advances to the next frame by itself. A control register holds the enable bit and a flush action. A count register reports how many complete frames are waiting. Two pulse outputs signal a stored frame and a discarded oversize frame.

The slot size is a parameter. The default of 128 bytes keeps the elaborated storage small. A deployment that needs full-size frames sets it to 2048, which raises the oversize limit to 2042 payload bytes.

Top module: `rxq_top`

## Requirements
- R1: After reset the frame count (read at offset 0x34) is 0, the control register (offset 0x08) reads 0, `reg_rdata` is 0, and both event outputs are low.
- R2: A frame is accepted only if control bit 0 (enable) is 1 when its start byte arrives. Otherwise the frame is not stored, the count does not change, and no event is raised.
- R3: If `SLOTS` frames (31 by default) are already queued, a new frame is rejected. Nothing is stored, the count stays at `SLOTS`, and no event is raised.
- R4: A frame whose payload is `SLOT_BYTES`-6 bytes or longer (122 by default) is discarded and the count does not change. For such a frame, `evt_ovr` is high for exactly the one cycle that follows the clock edge taking its last byte. A payload of `SLOT_BYTES`-7 bytes is stored normally.
- R5: The stored record holds, in this order:
  - byte 0: low byte of the length, which is payload size + 6;
  - byte 1: high byte of that length;
  - the payload bytes;
  - the four CRC bytes, least significant first;
  - zero bytes up to the next multiple of 4.
- R6: The CRC is the reflected CRC-32 with polynomial 0xEDB88320, an initial value of all ones and a final inversion, taken over the payload only. For the payload "123456789" it is 0xCBF43926.
- R7: A read at offset 0x10 returns four record bytes, little-endian: the lowest-addressed byte is in bits 7:0. The word appears on `reg_rdata` in the cycle after `reg_rd`.
  - Each such read advances the read offset by 4.
  - When the offset reaches or passes the stored length, the frame is released and the count drops by 1.
  - Frames are read back in arrival order. Slot indices wrap modulo `SLOTS`.
- R8: A read at offset 0x10 while the count is 0 returns 0 and changes nothing.
- R9: A write to the control register with bit 4 set does three things: it clears the count, clears the read offset, and abandons any frame being captured. After that, the next data read returns 0 until a new frame is stored.
- R10: For a stored frame of n payload bytes, `evt_rx` is high for exactly one cycle. It starts ceil4(n+6)−n clock edges after the edge that takes the last byte. The count rises by 1 on the edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_byte | input | 8 | Receive byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| evt_rx | output | 1 | One-cycle pulse when a frame is committed |
| evt_ovr | output | 1 | One-cycle pulse when an oversize frame is dropped |

## Verification
The hardest state to reach is a queue that is completely full while the head slot index has already wrapped around the end of the slot ring. In that state the write slot is computed modulo 31 from a head that is not zero. The stimulus first stores and drains several frames of different lengths, which moves the head partway around the ring. It then sends 32 frames back to back without reading, so that the last frame meets a full queue. Finally it drains the queue and compares every word. The payload sizes are chosen so that the zero padding covers all four possible tail lengths.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Register offsets (byte addresses)
  localparam logic [5:0] ADDR_CTRL  = 6'h08;
  localparam logic [5:0] ADDR_DATA  = 6'h10;
  localparam logic [5:0] ADDR_COUNT = 6'h34;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_FLUSH_BIT = 4;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_CAPTURE,
    WR_TAIL,
    WR_LENGTH
  } wr_state_e;

  // One byte of reflected CRC-32, LSB first
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rxq_writer.sv
module rxq_writer
  import rxq_pkg::*;
#(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 128,
  localparam int LIMIT = SLOT_BYTES - 6,
  localparam int PW    = $clog2(SLOT_BYTES) + 1,
  localparam int SW    = $clog2(SLOTS),
  localparam int WPS   = SLOT_BYTES / 4,
  localparam int MW    = $clog2(SLOTS * WPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic [7:0]    rx_byte,
  input  logic          enable,
  input  logic          full,
  input  logic          flush,
  input  logic [SW-1:0] tail_slot,
  output logic          mem_we,
  output logic [MW-1:0] mem_addr,
  output logic [1:0]    mem_lane,
  output logic [7:0]    mem_byte,
  output logic          commit,
  output logic          overrun
);

  wr_state_e      st_q, st_d;
  logic [PW-1:0]  pos_q, pos_d;     // payload bytes taken
  logic [PW-1:0]  tb_q, tb_d;       // record byte address in tail/length phases
  logic [31:0]    crc_q, crc_d;
  logic [SW-1:0]  slot_q, slot_d;
  logic           commit_q, commit_d;
  logic           ovr_q, ovr_d;

  logic [PW-1:0]  wb;
  logic [PW-1:0]  tail_end;
  logic [PW-1:0]  crc_sel;
  logic [15:0]    lenv;
  logic [31:0]    crc_fin;
  logic [31:0]    crc_shift;
  logic [SW-1:0]  wslot;

  assign lenv      = 16'(pos_q) + 16'd6;
  assign tail_end  = (pos_q + PW'(9)) & ~PW'(3);
  assign crc_fin   = ~crc_q;
  assign crc_sel   = tb_q - pos_q - PW'(2);
  assign crc_shift = crc_fin >> {crc_sel[1:0], 3'b000};

  always_comb begin
    st_d     = st_q;
    pos_d    = pos_q;
    tb_d     = tb_q;
    crc_d    = crc_q;
    slot_d   = slot_q;
    commit_d = 1'b0;
    ovr_d    = 1'b0;
    mem_we   = 1'b0;
    wb       = '0;
    mem_byte = 8'h00;
    unique case (st_q)
      WR_IDLE: begin
        if (rx_valid && rx_sof && enable && !full && !flush) begin
          mem_we   = 1'b1;
          wb       = PW'(2);
          mem_byte = rx_byte;
          pos_d    = PW'(1);
          crc_d    = crc32_byte('1, rx_byte);
          slot_d   = tail_slot;
          if (rx_eof) begin
            st_d = WR_TAIL;
            tb_d = PW'(3);
          end else begin
            st_d = WR_CAPTURE;
          end
        end
      end
      WR_CAPTURE: begin
        if (flush) begin
          st_d = WR_IDLE;
        end else if (rx_valid) begin
          if (pos_q < PW'(LIMIT)) begin
            mem_we   = 1'b1;
            wb       = pos_q + PW'(2);
            mem_byte = rx_byte;
            pos_d    = pos_q + PW'(1);
          end
          crc_d = crc32_byte(crc_q, rx_byte);
          if (rx_eof) begin
            if (pos_q + PW'(1) >= PW'(LIMIT)) begin
              ovr_d = 1'b1;
              st_d  = WR_IDLE;
            end else begin
              st_d = WR_TAIL;
              tb_d = pos_q + PW'(3);
            end
          end
        end
      end
      WR_TAIL: begin
        if (flush) begin
          st_d = WR_IDLE;
        end else begin
          mem_we   = 1'b1;
          wb       = tb_q;
          mem_byte = (crc_sel < PW'(4)) ? crc_shift[7:0] : 8'h00;
          tb_d     = tb_q + PW'(1);
          if (tb_q + PW'(1) == tail_end) begin
            st_d = WR_LENGTH;
            tb_d = '0;
          end
        end
      end
      WR_LENGTH: begin
        if (flush) begin
          st_d = WR_IDLE;
        end else begin
          mem_we   = 1'b1;
          wb       = tb_q;
          mem_byte = tb_q[0] ? lenv[15:8] : lenv[7:0];
          tb_d     = tb_q + PW'(1);
          if (tb_q[0]) begin
            st_d     = WR_IDLE;
            commit_d = 1'b1;
          end
        end
      end
    endcase
  end

  assign wslot    = (st_q == WR_IDLE) ? tail_slot : slot_q;
  assign mem_addr = MW'(wslot) * MW'(WPS) + MW'(wb >> 2);
  assign mem_lane = wb[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= WR_IDLE;
      pos_q    <= '0;
      tb_q     <= '0;
      crc_q    <= '1;
      slot_q   <= '0;
      commit_q <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      pos_q    <= pos_d;
      tb_q     <= tb_d;
      crc_q    <= crc_d;
      slot_q   <= slot_d;
      commit_q <= commit_d;
      ovr_q    <= ovr_d;
    end
  end

  assign commit  = commit_q;
  assign overrun = ovr_q;

endmodule

// File: rtl/rxq_reader.sv
module rxq_reader #(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 128,
  localparam int SW = $clog2(SLOTS),
  localparam int CW = $clog2(SLOTS + 1),
  localparam int OW = $clog2(SLOT_BYTES) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic          flush,
  input  logic          commit,
  input  logic [15:0]   head_len,
  output logic [SW-1:0] head,
  output logic [CW-1:0] count,
  output logic [OW-1:0] offset,
  output logic          pop
);

  logic [SW-1:0] head_q, head_d;
  logic [CW-1:0] count_q, count_d;
  logic [OW-1:0] off_q, off_d;
  logic [OW-1:0] off_next;
  logic          rel_frame;

  assign pop       = rd_req && (count_q != '0);
  assign off_next  = off_q + OW'(4);
  assign rel_frame = pop && (16'(off_next) >= head_len);

  always_comb begin
    head_d  = head_q;
    off_d   = off_q;
    count_d = count_q;
    if (flush) begin
      count_d = '0;
      off_d   = '0;
    end else begin
      if (pop) begin
        if (rel_frame) begin
          off_d  = '0;
          head_d = (head_q == SW'(SLOTS - 1)) ? '0 : head_q + SW'(1);
        end else begin
          off_d = off_next;
        end
      end
      count_d = count_q + CW'(commit) - CW'(rel_frame);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      count_q <= '0;
      off_q   <= '0;
    end else begin
      head_q  <= head_d;
      count_q <= count_d;
      off_q   <= off_d;
    end
  end

  assign head   = head_q;
  assign count  = count_q;
  assign offset = off_q;

endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [7:0]  rx_byte,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        evt_rx,
  output logic        evt_ovr
);

  localparam int SW    = $clog2(SLOTS);
  localparam int CW    = $clog2(SLOTS + 1);
  localparam int OW    = $clog2(SLOT_BYTES) + 1;
  localparam int WPS   = SLOT_BYTES / 4;
  localparam int DEPTH = SLOTS * WPS;
  localparam int MW    = $clog2(DEPTH);
  localparam int TW    = SW + 2;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic [31:0]   ctrl_q, ctrl_d;
  logic [31:0]   rdata_q, rdata_d;
  logic          flush, rd_req;
  logic          commit, overrun, pop, full;
  logic [SW-1:0] head, tail;
  logic [CW-1:0] count;
  logic [OW-1:0] offset;
  logic [TW-1:0] tsum;
  logic          mem_we;
  logic [MW-1:0] mem_addr;
  logic [1:0]    mem_lane;
  logic [7:0]    mem_byte;
  logic [MW-1:0] hbase;
  logic [31:0]   rd_word;
  logic [15:0]   head_len;

  logic [31:0] mem [DEPTH];

  assign flush  = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[CTRL_FLUSH_BIT];
  assign rd_req = reg_rd && (reg_addr == ADDR_DATA);
  assign full   = ({1'b0, count} + {{CW{1'b0}}, commit}) >= (CW + 1)'(SLOTS);
  assign tsum   = TW'(head) + TW'(count) + TW'(commit);
  assign tail   = SW'((tsum >= TW'(SLOTS)) ? tsum - TW'(SLOTS) : tsum);

  rxq_writer #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_wr (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .rx_valid (rx_valid),
    .rx_sof   (rx_sof),
    .rx_eof   (rx_eof),
    .rx_byte  (rx_byte),
    .enable   (ctrl_q[CTRL_EN_BIT]),
    .full     (full),
    .flush    (flush),
    .tail_slot(tail),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_lane (mem_lane),
    .mem_byte (mem_byte),
    .commit   (commit),
    .overrun  (overrun)
  );

  rxq_reader #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_rd (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .rd_req  (rd_req),
    .flush   (flush),
    .commit  (commit),
    .head_len(head_len),
    .head    (head),
    .count   (count),
    .offset  (offset),
    .pop     (pop)
  );

  // Frame storage, byte-lane writes
  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr][{mem_lane, 3'b000} +: 8] <= mem_byte;
  end

  assign hbase    = MW'(head) * MW'(WPS);
  assign rd_word  = mem[hbase + MW'(offset >> 2)];
  assign head_len = mem[hbase][15:0];

  always_comb begin
    ctrl_d = ctrl_q;
    if (reg_wr && (reg_addr == ADDR_CTRL)) ctrl_d = reg_wdata;
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL:  rdata_d = ctrl_q;
      ADDR_DATA:  rdata_d = (count != '0) ? rd_word : 32'h0;
      ADDR_COUNT: rdata_d = 32'(count);
      default:    rdata_d = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q  <= '0;
      rdata_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (reg_rd) rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign evt_rx    = commit;
  assign evt_ovr   = overrun;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int SLOTS = 31,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count,
  input logic          commit,
  input logic          pop,
  input logic          flush,
  input logic          rd_req,
  input logic          evt_rx,
  input logic          evt_ovr
);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(SLOTS));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(SLOTS) && !pop && !flush) |=> (count == CW'(SLOTS)));

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !commit && !pop) |=> $stable(count));

  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && count == '0 && !commit && !flush) |=> (count == '0));

  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  p_evt_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_rx && evt_ovr));

  p_evt_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx |=> !evt_rx);

endmodule

bind rxq_top rxq_checker #(.SLOTS(SLOTS), .CW(CW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_s_n),
  .count  (count),
  .commit (commit),
  .pop    (pop),
  .flush  (flush),
  .rd_req (rd_req),
  .evt_rx (evt_rx),
  .evt_ovr(evt_ovr)
);

// File: tb/sim_rxq_top.sv
module sim_rxq_top;
  import rxq_pkg::*;

  localparam int SLOTS      = 31;
  localparam int SLOT_BYTES = 128;
  localparam int LIMIT      = SLOT_BYTES - 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = 6'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        evt_rx, evt_ovr;

  always #5 clk = ~clk;

  rxq_top #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_byte(rx_byte), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_rx(evt_rx), .evt_ovr(evt_ovr)
  );

  int checks = 0, errors = 0, cyc = 0;
  int exp_rx_cyc = -1, exp_ovr_cyc = -1;
  bit done = 1'b0;
  logic [7:0]  m_bytes[$];
  int          m_len[$];
  int          m_off = 0;
  logic [31:0] m_ctrl = 32'h0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [7:0] d[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (d[i]) begin
      c = c ^ {24'h0, d[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  // Event outputs compared against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (evt_rx || cyc == exp_rx_cyc)
        check(evt_rx == (cyc == exp_rx_cyc), "R10 evt_rx timing", 32'(evt_rx), 32'(cyc == exp_rx_cyc));
      if (evt_ovr || cyc == exp_ovr_cyc)
        check(evt_ovr == (cyc == exp_ovr_cyc), "R4 evt_ovr timing", 32'(evt_ovr), 32'(cyc == exp_ovr_cyc));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
    if (a == ADDR_CTRL) begin
      m_ctrl = d;
      if (d[CTRL_FLUSH_BIT]) begin
        m_bytes.delete(); m_len.delete(); m_off = 0;
      end
    end
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = a;
    tick();
    reg_rd = 1'b0;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic check_count(input string tag);
    logic [31:0] v;
    reg_read(ADDR_COUNT, v);
    check(v == 32'(m_len.size()), tag, v, 32'(m_len.size()));
  endtask

  task automatic read_data(input string tag, output logic [31:0] act);
    logic [31:0] exp = 32'h0;
    if (m_len.size() != 0) begin
      exp = {m_bytes[3], m_bytes[2], m_bytes[1], m_bytes[0]};
      for (int k = 0; k < 4; k++) void'(m_bytes.pop_front());
      m_off += 4;
      if (m_off >= m_len[0]) begin
        m_off = 0;
        void'(m_len.pop_front());
      end
    end
    reg_read(ADDR_DATA, act);
    check(act == exp, tag, act, exp);
  endtask

  task automatic drain(input string tag);
    logic [31:0] v;
    while (m_len.size() != 0) read_data(tag, v);
  endtask

  // seed 0 gives the ASCII digits '1','2',...
  task automatic send_frame(input int n, input int seed);
    logic [7:0] pl[$];
    logic [31:0] crc;
    bit acc, ovs;
    int c_last, rec;
    for (int i = 0; i < n; i++) pl.push_back((seed == 0) ? 8'(8'h31 + i) : 8'((i * 7 + seed * 13) & 255));
    acc = m_ctrl[CTRL_EN_BIT] && (m_len.size() < SLOTS);
    ovs = (n >= LIMIT);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == n - 1); rx_byte = pl[i];
      tick();
    end
    c_last = cyc;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    if (acc && ovs) begin
      exp_ovr_cyc = c_last;
    end else if (acc) begin
      rec = ((n + 6 + 3) / 4) * 4;
      exp_rx_cyc = c_last + rec - n;
      crc = ref_crc(pl);
      m_bytes.push_back(8'((n + 6) & 255));
      m_bytes.push_back(8'((n + 6) >> 8));
      foreach (pl[i]) m_bytes.push_back(pl[i]);
      for (int k = 0; k < 4; k++) m_bytes.push_back(crc[8*k +: 8]);
      for (int k = n + 6; k < rec; k++) m_bytes.push_back(8'h00);
      m_len.push_back(n + 6);
    end
    repeat (14) tick();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, w0, w1, w2, w3;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) tick();

    // R1 reset state
    @(negedge clk);
    check(reg_rdata == 32'h0, "R1 rdata after reset", reg_rdata, 32'h0);
    check({evt_rx, evt_ovr} == 2'b00, "R1 events after reset", 32'({evt_rx, evt_ovr}), 32'h0);
    reg_read(ADDR_CTRL, v);
    check(v == 32'h0, "R1 control after reset", v, 32'h0);
    check_count("R1 count after reset");

    // R2 disabled: frame ignored
    send_frame(10, 3);
    check_count("R2 count with enable low");
    reg_write(ADDR_CTRL, 32'h1);

    // R5/R6 known CRC vector
    check(ref_crc('{8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39}) == 32'hCBF43926,
          "R6 reference crc", ref_crc('{8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39}), 32'hCBF43926);
    send_frame(9, 0);
    check_count("R10 count after one frame");
    read_data("R5 word0", w0);
    read_data("R5 word1", w1);
    read_data("R6 word2", w2);
    read_data("R6 word3", w3);
    check(w0 == 32'h3231000F, "R5 length prefix", w0, 32'h3231000F);
    check(w2 == 32'h26393837, "R6 crc low bytes", w2, 32'h26393837);
    check(w3 == 32'h00CBF439, "R6 crc high bytes and zero fill", w3, 32'h00CBF439);
    check_count("R7 count after frame read");

    // R5/R7 several sizes covering each pad length
    send_frame(1, 1);
    send_frame(2, 2);
    send_frame(3, 3);
    send_frame(4, 4);
    send_frame(5, 5);
    send_frame(60, 6);
    check_count("R10 count after six frames");
    drain("R7 readback sizes");
    check_count("R7 count after drain");

    // R8 empty read
    read_data("R8 empty read value", v);
    check_count("R8 count after empty read");

    // R4 oversize boundary
    send_frame(LIMIT, 7);
    check_count("R4 count after oversize");
    send_frame(LIMIT - 1, 8);
    check_count("R4 count after largest frame");
    drain("R4 largest frame readback");

    // R3 full queue, head already wrapped past slot 0
    for (int i = 0; i < SLOTS + 1; i++) send_frame(3 + (i % 5), 9 + i);
    check_count("R3 count when full");
    drain("R3 readback of full queue");
    check_count("R3 count after drain");

    // R9 flush mid-read
    send_frame(7, 40);
    send_frame(8, 41);
    read_data("R9 partial read", v);
    reg_write(ADDR_CTRL, 32'h11);
    check_count("R9 count after flush");
    read_data("R9 read after flush", v);
    send_frame(6, 42);
    drain("R9 frame after flush");
    check_count("R9 count after drain");

    // R2 disable again
    reg_write(ADDR_CTRL, 32'h0);
    send_frame(12, 43);
    check_count("R2 count after disable");

    repeat (5) tick();
    finish_run();
  end

endmodule